// File: doc/BRIEF.md
# Two-Slot Instruction Issue Decoder

This block sits at the front of a simple in-order core. Every memory word it reads is 48 bits wide and carries two 24-bit instructions. The block issues the left one first, then the right one. It presents the program counter as the fetch address and expects the memory word at that address on `mem_word_i` in the same cycle. Each cycle that the execute stage raises `step_i`, the block takes the current half of that word and splits it into an index register number, an opcode and an address, then registers the result. It supports two instruction layouts: a long one with a 15-bit address and a short one with a 12-bit address that can be extended upward.

Execute logic can leave a one-shot address offset for the next instruction it receives. It does this by pulsing `mod_valid_i` with the value. The block adds that offset, modulo 2^15, to the address of the next instruction it issues and then discards it. A taken branch reloads the counter and restarts issue at the left half of the target word.

Top module: `twin_slot_decoder`

## Requirements
- R1: While reset is held and after it is released, `fetch_addr_o` is 1, `slot_o` is 0 (left half) and `dec_valid_o` is 0.
- R2: Within one word, the instruction in bits 47:24 issues first and the one in bits 23:0 second. `dec_slot_o` is 0 for the first and 1 for the second, and `dec_pc_o` carries the word address both came from.
- R3: After the left instruction issues, only `slot_o` changes. After the right instruction issues, `fetch_addr_o` increments by one modulo 2^15 (7FFF hex wraps to 0) and `slot_o` returns to 0.
- R4: `dec_reg_o` is instruction bits 23:20.
- R5: When instruction bit 20 is 1 (long layout, `dec_long_o`=1), the address is bits 14:0. The 8-bit opcode has bits 19:15 in its upper five bits and zeros in its low three bits.
- R6: When bit 20 is 0 (short layout), the address is bits 11:0 and the opcode is bits 17:12 zero-extended to 8 bits.
- R7: In the short layout, when bit 19 is 1, address bits 14:12 are forced to 1. When bit 19 is 0, they are 0.
- R8: A value given with `mod_valid_i` is added modulo 2^15 to the address of the next issued instruction only. The instruction after that is unmodified unless a new value arrives.
- R9: When `branch_i` is 1, the next `fetch_addr_o` is `branch_target_i` and the next `slot_o` is 0. Nothing issues in that cycle, even if `step_i` is 1.
- R10: `dec_valid_o` is 1 for exactly the cycle after each cycle with `step_i`=1 and `branch_i`=0, and 0 otherwise. The decoded outputs hold their values until the next issue.
- R11: A modifier given in the same cycle as an issue does not alter that instruction. It applies to the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Issue the currently selected instruction |
| mem_word_i | input | 48 | Memory word at `fetch_addr_o` |
| branch_i | input | 1 | Taken branch, redirects the counter |
| branch_target_i | input | 15 | Branch destination word address |
| mod_valid_i | input | 1 | Modifier value present |
| mod_value_i | input | 15 | Offset for the next issued instruction |
| fetch_addr_o | output | 15 | Program counter, word address to read |
| slot_o | output | 1 | Half to issue next (0 left, 1 right) |
| dec_valid_o | output | 1 | One-cycle pulse: decoded fields are new |
| dec_reg_o | output | 4 | Index register number |
| dec_opcode_o | output | 8 | Opcode |
| dec_addr_o | output | 15 | Address after modification |
| dec_long_o | output | 1 | Instruction used the long layout |
| dec_pc_o | output | 15 | Word address of the issued instruction |
| dec_slot_o | output | 1 | Half the issued instruction came from |

## Verification
The hardest conditions to reach are the interactions of the one-shot modifier with timing. Three cases matter: a modifier arriving in the very cycle an instruction issues, a modifier arriving on an idle or branch cycle, and a modified address that wraps past 7FFF.

The bench reaches each case with directed calls before a long random phase. In the random phase, branch, step and modifier pulses overlap freely. A reference model in the bench follows its own counter, half flag and pending offset for every one of these cases.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
   // half-word selector encoding, left half issues first
   typedef enum logic {
      SLOT_LEFT  = 1'b0,
      SLOT_RIGHT = 1'b1
   } half_e;

   localparam int DEF_WORD_W  = 48;
   localparam int DEF_INSN_W  = 24;
   localparam int DEF_ADDR_W  = 15;
   localparam int DEF_REG_W   = 4;
   localparam int DEF_OPC_W   = 8;
endpackage

// File: rtl/tsd_pc_seq.sv
module tsd_pc_seq #(
   parameter int ADDR_W    = 15,
   parameter int NUM_SLOTS = 2,
   parameter int SLOT_W    = 1,
   parameter int RESET_PC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance_i,
   input  logic              branch_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [SLOT_W-1:0] slot_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
   localparam logic [ADDR_W-1:0] PC_INIT   = ADDR_W'(RESET_PC);

   logic [ADDR_W-1:0] pc_q;
   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= PC_INIT;
         slot_q <= '0;
      end else if (branch_i) begin
         pc_q   <= target_i;
         slot_q <= '0;
      end else if (advance_i) begin
         if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
            pc_q   <= pc_q + 1'b1;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign pc_o   = pc_q;
   assign slot_o = slot_q;
endmodule

// File: rtl/tsd_slot_select.sv
module tsd_slot_select #(
   parameter int WORD_W    = 48,
   parameter int INSN_W    = 24,
   parameter int NUM_SLOTS = 2,
   parameter int SLOT_W    = 1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [SLOT_W-1:0] slot_i,
   output logic [INSN_W-1:0] insn_o
);
   logic [INSN_W-1:0] part [NUM_SLOTS];

   // slot 0 is the most significant part of the word
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_part
      assign part[s] = word_i[WORD_W-1-s*INSN_W -: INSN_W];
   end

   assign insn_o = part[slot_i];
endmodule

// File: rtl/tsd_field_extract.sv
module tsd_field_extract #(
   parameter int INSN_W       = 24,
   parameter int ADDR_W       = 15,
   parameter int REG_W        = 4,
   parameter int OPC_W        = 8,
   parameter int SHORT_ADDR_W = 12,
   parameter int SHORT_OP_W   = 6,
   parameter int LONG_OP_W    = 5
) (
   input  logic [INSN_W-1:0] insn_i,
   output logic [REG_W-1:0]  reg_o,
   output logic [OPC_W-1:0]  opcode_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              long_o
);
   localparam int REG_LSB      = INSN_W - REG_W;
   localparam int FMT_BIT      = REG_LSB;
   localparam int EXT_BIT      = REG_LSB - 1;
   localparam int LONG_OP_LSB  = EXT_BIT - LONG_OP_W + 1;
   localparam int SHORT_OP_LSB = SHORT_ADDR_W;
   localparam int EXT_W        = ADDR_W - SHORT_ADDR_W;
   localparam int LONG_PAD     = OPC_W - LONG_OP_W;
   localparam int SHORT_PAD    = OPC_W - SHORT_OP_W;

   if (LONG_OP_LSB < ADDR_W) begin : g_bad_long
      $error("long opcode field overlaps the address field");
   end
   if (SHORT_OP_LSB + SHORT_OP_W > EXT_BIT) begin : g_bad_short
      $error("short opcode field overlaps the extension bit");
   end
   if (EXT_W < 1 || LONG_PAD < 1 || SHORT_PAD < 1) begin : g_bad_pad
      $error("field widths leave no room for padding");
   end

   logic              is_long;
   logic [ADDR_W-1:0] long_addr, short_addr;
   logic [OPC_W-1:0]  long_op, short_op;

   assign is_long    = insn_i[FMT_BIT];
   assign long_addr  = insn_i[ADDR_W-1:0];
   assign short_addr = {{EXT_W{insn_i[EXT_BIT]}}, insn_i[SHORT_ADDR_W-1:0]};
   assign long_op    = {insn_i[LONG_OP_LSB +: LONG_OP_W], {LONG_PAD{1'b0}}};
   assign short_op   = {{SHORT_PAD{1'b0}}, insn_i[SHORT_OP_LSB +: SHORT_OP_W]};

   always_comb begin
      reg_o  = insn_i[INSN_W-1 -: REG_W];
      long_o = is_long;
      if (is_long) begin
         opcode_o = long_op;
         addr_o   = long_addr;
      end else begin
         opcode_o = short_op;
         addr_o   = short_addr;
      end
   end
endmodule

// File: rtl/tsd_modifier.sv
module tsd_modifier #(
   parameter int ADDR_W     = 15,
   parameter bit MOD_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic              mod_valid_i,
   input  logic [ADDR_W-1:0] mod_value_i,
   input  logic [ADDR_W-1:0] addr_raw_i,
   output logic [ADDR_W-1:0] addr_o
);
   if (MOD_ENABLE) begin : g_mod
      logic [ADDR_W-1:0] pend_q;

      // an issue consumes the pending offset; a value arriving with it
      // is kept for the instruction after
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= '0;
         end else if (issue_i) begin
            pend_q <= mod_valid_i ? mod_value_i : '0;
         end else if (mod_valid_i) begin
            pend_q <= mod_value_i;
         end
      end

      assign addr_o = addr_raw_i + pend_q;
   end else begin : g_nomod
      logic unused_in;
      assign unused_in = &{1'b0, clk, rst_n, issue_i, mod_valid_i, mod_value_i};
      assign addr_o    = addr_raw_i;
   end
endmodule

// File: rtl/twin_slot_decoder.sv
module twin_slot_decoder
   import tsd_pkg::*;
#(
   parameter int WORD_W       = DEF_WORD_W,
   parameter int INSN_W       = DEF_INSN_W,
   parameter int ADDR_W       = DEF_ADDR_W,
   parameter int REG_W        = DEF_REG_W,
   parameter int OPC_W        = DEF_OPC_W,
   parameter int SHORT_ADDR_W = 12,
   parameter int SHORT_OP_W   = 6,
   parameter int LONG_OP_W    = 5,
   parameter int RESET_PC     = 1,
   parameter bit MOD_ENABLE   = 1'b1,
   localparam int NUM_SLOTS   = WORD_W / INSN_W,
   localparam int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic [WORD_W-1:0] mem_word_i,
   input  logic              branch_i,
   input  logic [ADDR_W-1:0] branch_target_i,
   input  logic              mod_valid_i,
   input  logic [ADDR_W-1:0] mod_value_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              dec_valid_o,
   output logic [REG_W-1:0]  dec_reg_o,
   output logic [OPC_W-1:0]  dec_opcode_o,
   output logic [ADDR_W-1:0] dec_addr_o,
   output logic              dec_long_o,
   output logic [ADDR_W-1:0] dec_pc_o,
   output logic [SLOT_W-1:0] dec_slot_o
);
   if (WORD_W % INSN_W != 0 || NUM_SLOTS < 2) begin : g_bad_word
      $error("word must hold a whole number (>=2) of instructions");
   end
   if (RESET_PC < 0 || RESET_PC >= (1 << ADDR_W)) begin : g_bad_rst
      $error("reset counter value does not fit the address width");
   end

   logic              issue;
   logic [ADDR_W-1:0] pc;
   logic [SLOT_W-1:0] slot;
   logic [INSN_W-1:0] insn;
   logic [REG_W-1:0]  f_reg;
   logic [OPC_W-1:0]  f_op;
   logic [ADDR_W-1:0] f_addr_raw, f_addr;
   logic              f_long;

   // a branch wins over a sequential issue in the same cycle
   assign issue = step_i & ~branch_i;

   tsd_pc_seq #(
      .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .RESET_PC(RESET_PC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .advance_i(issue), .branch_i(branch_i),
      .target_i(branch_target_i), .pc_o(pc), .slot_o(slot)
   );

   tsd_slot_select #(
      .WORD_W(WORD_W), .INSN_W(INSN_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
   ) u_sel (
      .word_i(mem_word_i), .slot_i(slot), .insn_o(insn)
   );

   tsd_field_extract #(
      .INSN_W(INSN_W), .ADDR_W(ADDR_W), .REG_W(REG_W), .OPC_W(OPC_W),
      .SHORT_ADDR_W(SHORT_ADDR_W), .SHORT_OP_W(SHORT_OP_W), .LONG_OP_W(LONG_OP_W)
   ) u_fld (
      .insn_i(insn), .reg_o(f_reg), .opcode_o(f_op), .addr_o(f_addr_raw), .long_o(f_long)
   );

   tsd_modifier #(
      .ADDR_W(ADDR_W), .MOD_ENABLE(MOD_ENABLE)
   ) u_mod (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .mod_valid_i(mod_valid_i),
      .mod_value_i(mod_value_i), .addr_raw_i(f_addr_raw), .addr_o(f_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid_o  <= 1'b0;
         dec_reg_o    <= '0;
         dec_opcode_o <= '0;
         dec_addr_o   <= '0;
         dec_long_o   <= 1'b0;
         dec_pc_o     <= '0;
         dec_slot_o   <= '0;
      end else begin
         dec_valid_o <= issue;
         if (issue) begin
            dec_reg_o    <= f_reg;
            dec_opcode_o <= f_op;
            dec_addr_o   <= f_addr;
            dec_long_o   <= f_long;
            dec_pc_o     <= pc;
            dec_slot_o   <= slot;
         end
      end
   end

   assign fetch_addr_o = pc;
   assign slot_o       = slot;
endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
   parameter int ADDR_W    = 15,
   parameter int SLOT_W    = 1,
   parameter int NUM_SLOTS = 2,
   parameter int OPC_W     = 8,
   parameter int LONG_OP_W = 5,
   parameter int SHORT_OP_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_i,
   input logic              branch_i,
   input logic [ADDR_W-1:0] branch_target_i,
   input logic [ADDR_W-1:0] fetch_addr_o,
   input logic [SLOT_W-1:0] slot_o,
   input logic              dec_valid_o,
   input logic [OPC_W-1:0]  dec_opcode_o,
   input logic              dec_long_o,
   input logic [ADDR_W-1:0] dec_pc_o,
   input logic [SLOT_W-1:0] dec_slot_o
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);
   localparam int LOW_Z  = OPC_W - LONG_OP_W;
   localparam int HIGH_Z = OPC_W - SHORT_OP_W;

   p_issue_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !branch_i) |=> dec_valid_o);

   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_i && !branch_i) |=> !dec_valid_o);

   p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      branch_i |=> (fetch_addr_o == $past(branch_target_i)) && (slot_o == '0));

   p_left_holds_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !branch_i && slot_o != LAST) |=>
         $stable(fetch_addr_o) && (slot_o == SLOT_W'($past(slot_o) + 1'b1)));

   p_right_bumps_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !branch_i && slot_o == LAST) |=>
         (fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1)) && (slot_o == '0));

   p_issue_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !branch_i) |=>
         (dec_pc_o == $past(fetch_addr_o)) && (dec_slot_o == $past(slot_o)));

   p_long_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_long_o) |-> (dec_opcode_o[LOW_Z-1:0] == '0));

   p_short_opcode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && !dec_long_o) |-> (dec_opcode_o[OPC_W-1 -: HIGH_Z] == '0));

   p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !branch_i) |=> $stable(fetch_addr_o) && $stable(slot_o));
endmodule

bind twin_slot_decoder tsd_checker #(
   .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .OPC_W(OPC_W),
   .LONG_OP_W(LONG_OP_W), .SHORT_OP_W(SHORT_OP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_i(step_i), .branch_i(branch_i),
   .branch_target_i(branch_target_i), .fetch_addr_o(fetch_addr_o), .slot_o(slot_o),
   .dec_valid_o(dec_valid_o), .dec_opcode_o(dec_opcode_o), .dec_long_o(dec_long_o),
   .dec_pc_o(dec_pc_o), .dec_slot_o(dec_slot_o)
);

// File: tb/twin_slot_decoder_tb.sv
`timescale 1ns/1ps
module twin_slot_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0;
   logic [47:0] mem_word_i = '0;
   logic        branch_i = 1'b0;
   logic [14:0] branch_target_i = '0;
   logic        mod_valid_i = 1'b0;
   logic [14:0] mod_value_i = '0;
   logic [14:0] fetch_addr_o;
   logic        slot_o;
   logic        dec_valid_o;
   logic [3:0]  dec_reg_o;
   logic [7:0]  dec_opcode_o;
   logic [14:0] dec_addr_o;
   logic        dec_long_o;
   logic [14:0] dec_pc_o;
   logic        dec_slot_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [3:0]  rg;
      logic [7:0]  op;
      logic [14:0] ad;
      logic        lng;
      logic [14:0] pc;
      logic        sl;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   logic [47:0] mem [int];

   logic [14:0] m_pc = 15'd1;
   logic        m_slot = 1'b0;
   logic [14:0] m_mod = '0;
   bit          m_prev_issue = 1'b0;
   logic [14:0] m_last_addr = '0;

   always #2.5 clk = ~clk;

   twin_slot_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .mem_word_i(mem_word_i),
      .branch_i(branch_i), .branch_target_i(branch_target_i),
      .mod_valid_i(mod_valid_i), .mod_value_i(mod_value_i),
      .fetch_addr_o(fetch_addr_o), .slot_o(slot_o), .dec_valid_o(dec_valid_o),
      .dec_reg_o(dec_reg_o), .dec_opcode_o(dec_opcode_o), .dec_addr_o(dec_addr_o),
      .dec_long_o(dec_long_o), .dec_pc_o(dec_pc_o), .dec_slot_o(dec_slot_o)
   );

   function automatic logic [47:0] word_at(input logic [14:0] a);
      logic [47:0] h;
      if (mem.exists(int'(a))) return mem[int'(a)];
      h = 48'({33'b0, a} * 48'h9E37_79B9_7F4A) ^ 48'h1234_5678_9ABC;
      return h;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // driver: one cycle of stimulus, model update and expectation push
   task automatic drive(input bit st, input bit br, input logic [14:0] tgt,
                        input bit mv, input logic [14:0] mval, input string tag);
      logic [47:0] w;
      logic [23:0] ins;
      exp_t e;
      @(negedge clk);
      check(fetch_addr_o == m_pc, tag, "fetch_addr", 32'(fetch_addr_o), 32'(m_pc));
      check(slot_o == m_slot, tag, "slot", 32'(slot_o), 32'(m_slot));
      if (!m_prev_issue) begin
         // R10: no pulse and fields held while nothing issued
         check(dec_valid_o == 1'b0, "R10", "idle valid", 32'(dec_valid_o), 32'h0);
         check(dec_addr_o == m_last_addr, "R10", "held addr", 32'(dec_addr_o), 32'(m_last_addr));
      end
      w = word_at(m_pc);
      step_i = st; branch_i = br; branch_target_i = tgt;
      mod_valid_i = mv; mod_value_i = mval; mem_word_i = w;
      if (br) begin
         m_pc = tgt; m_slot = 1'b0;
         if (mv) m_mod = mval;
         m_prev_issue = 1'b0;
      end else if (st) begin
         ins = m_slot ? w[23:0] : w[47:24];
         e.rg = ins[23:20];
         e.lng = ins[20];
         if (ins[20]) begin
            e.ad = ins[14:0];
            e.op = {ins[19:15], 3'b000};
         end else begin
            e.ad = {{3{ins[19]}}, ins[11:0]};
            e.op = {2'b00, ins[17:12]};
         end
         e.ad = e.ad + m_mod;
         e.pc = m_pc; e.sl = m_slot; e.tag = tag;
         exp_q.push_back(e);
         m_last_addr = e.ad;
         m_mod = mv ? mval : 15'd0;
         if (m_slot) begin m_slot = 1'b0; m_pc = m_pc + 15'd1; end
         else m_slot = 1'b1;
         m_prev_issue = 1'b1;
      end else begin
         if (mv) m_mod = mval;
         m_prev_issue = 1'b0;
      end
   endtask

   // monitor: pop and compare when the design reports a decode
   always @(negedge clk) begin
      if (rst_n && dec_valid_o) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R10 unexpected valid actual=1 expected=0");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(dec_reg_o == e.rg, {e.tag, " R4"}, "reg", 32'(dec_reg_o), 32'(e.rg));
            check(dec_opcode_o == e.op, {e.tag, " R5 R6"}, "opcode", 32'(dec_opcode_o), 32'(e.op));
            check(dec_addr_o == e.ad, {e.tag, " R7 R8"}, "addr", 32'(dec_addr_o), 32'(e.ad));
            check(dec_long_o == e.lng, {e.tag, " R5"}, "long", 32'(dec_long_o), 32'(e.lng));
            check(dec_pc_o == e.pc, {e.tag, " R2"}, "pc", 32'(dec_pc_o), 32'(e.pc));
            check(dec_slot_o == e.sl, {e.tag, " R2"}, "slot", 32'(dec_slot_o), 32'(e.sl));
         end
      end
   end

   bit done = 1'b0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // long | short-no-ext, then short-ext | long
      mem[1] = {24'hB9_2345, 24'h42_ABCD};
      mem[2] = {24'h68_8123, 24'h3F_FFFF};
      mem[16'h100] = {24'h1A_5001, 24'hCC_7777};
      mem[16'h7FFF] = {24'h5F_F00F, 24'h00_0000};
      mem[16'h7FF0] = {24'h10_7FF0, 24'h2D_0FFF};

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(fetch_addr_o == 15'd1, "R1", "reset pc", 32'(fetch_addr_o), 32'd1);
      check(slot_o == 1'b0, "R1", "reset slot", 32'(slot_o), 32'd0);
      check(dec_valid_o == 1'b0, "R1", "reset valid", 32'(dec_valid_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(fetch_addr_o == 15'd1 && slot_o == 1'b0, "R1", "after release",
            32'({fetch_addr_o, slot_o}), 32'({15'd1, 1'b0}));

      // R2 R3 R4 R5 R6 R7: sequential issue across two words
      drive(1, 0, 0, 0, 0, "R2");
      drive(1, 0, 0, 0, 0, "R6");
      drive(1, 0, 0, 0, 0, "R7");
      drive(1, 0, 0, 0, 0, "R3");
      drive(0, 0, 0, 0, 0, "R10");
      drive(0, 0, 0, 0, 0, "R10");
      // R11: modifier in the issue cycle goes to the next instruction
      drive(1, 0, 0, 1, 15'h0010, "R11");
      drive(1, 0, 0, 0, 0, "R8");
      drive(1, 0, 0, 0, 0, "R8");
      // R8: modifier on an idle cycle, wrapping past 7FFF
      drive(0, 1, 15'h7FF0, 0, 0, "R9");
      drive(0, 0, 0, 1, 15'h0020, "R8");
      drive(1, 0, 0, 0, 0, "R8");
      drive(1, 0, 0, 0, 0, "R8");
      // R9: branch beats step after a left issue
      drive(1, 0, 0, 0, 0, "R9");
      drive(1, 1, 15'h0100, 0, 0, "R9");
      drive(1, 0, 0, 0, 0, "R9");
      drive(1, 0, 0, 0, 0, "R9");
      // R3: counter wrap
      drive(0, 1, 15'h7FFF, 0, 0, "R3");
      drive(1, 0, 0, 0, 0, "R3");
      drive(1, 0, 0, 0, 0, "R3");
      drive(0, 0, 0, 0, 0, "R3");
      // random mix
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 99);
         drive(r < 80, r >= 92, 15'($urandom), ($urandom_range(0, 9) < 3),
               15'($urandom), "R8");
      end
      drive(0, 0, 0, 0, 0, "R10");
      drive(0, 0, 0, 0, 0, "R10");
      @(negedge clk);
      check(exp_q.size() == 0, "R10", "leftover expectations", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule